// File: doc/BRIEF.md
# Latency-Insensitive Read Port for a Fixed-Latency Synchronous Memory

This block sits in front of a synchronous memory whose read data always appears a fixed number of cycles (`LAT`) after the read is issued. The memory itself cannot stall. The block turns it into a read port with flow control on both sides. Read requests come in on a valid/ready channel, and responses go out on a second valid/ready channel. The consumer may hold off responses for as long as it likes, and no data is lost.

Each returned word is written into a small output FIFO of `DEPTH` entries. A credit counter holds the number of reads in flight plus the responses waiting in the FIFO. A new read is admitted only while that counter is below `DEPTH`, so every issued read already owns a FIFO slot when its data arrives. A shift register of valid bits, `LAT` stages long, marks the cycles in which the memory's data bus carries a real answer.

Back-pressure rules:
- On the request side, a transfer happens on a cycle where `req_valid_i` and `req_ready_o` are both high.
- On the response side, a transfer happens where `rsp_valid_o` and `rsp_ready_i` are both high.
- `rsp_valid_o` and `rsp_data_o` stay put until they are taken.
- `req_ready_o` depends only on registered state, never on `req_valid_i` or `rsp_ready_i` in the same cycle.

Top module: `lim_mem_wrap`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_en_o` are 0.
- R2: `mem_en_o` is high exactly in cycles where `req_valid_i` and `req_ready_o` are both high. In that cycle `mem_addr_o` equals `req_addr_i`.
- R3: A read accepted at clock edge E has the value on `mem_rdata_i` during the cycle before edge E+LAT captured at edge E+LAT. It is presented on `rsp_valid_o`/`rsp_data_o` right after that edge, and responses leave in request order.
- R4: The credit count rises by 1 on a request transfer and falls by 1 on a response transfer. It is unchanged when both happen in the same cycle. `req_ready_o` is high exactly while the count is below `DEPTH`.
- R5: With `rsp_ready_i` held low from an empty state, exactly `DEPTH` requests are accepted, then `req_ready_o` stays low and no response is lost.
- R6: While `rsp_valid_o` is high and `rsp_ready_i` is low, `rsp_valid_o` stays high and `rsp_data_o` stays unchanged.
- R7: A response transfer while the count equals `DEPTH` does not raise `req_ready_o` in that cycle. It raises it in the next cycle.
- R8: Values on `mem_rdata_i` in cycles that carry no issued read are ignored and never produce a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Read request can be taken |
| req_addr_i | input | AW | Read address |
| rsp_valid_o | output | 1 | Oldest response available (peek valid) |
| rsp_ready_i | input | 1 | Consumer takes the response (dequeue) |
| rsp_data_o | output | DW | Oldest response data (peek) |
| mem_en_o | output | 1 | Read enable to the memory |
| mem_addr_o | output | AW | Address to the memory |
| mem_rdata_i | input | DW | Memory read data, valid LAT cycles after enable |

## Verification
A request transfer and a response transfer can fall in the same cycle, and the credit count must then stay where it was.

The bench provokes this in two situations:
- With the count one below `DEPTH`, it fires both transfers together. It then judges at the ports that `req_ready_o` is still high, and that exactly one further request brings it low.
- With the count at `DEPTH`, it offers a request together with a dequeue. It checks that the request is refused in that cycle and that `req_ready_o` returns on the next one.

A randomly stalled stream is compared response by response against the addresses issued, checking both value and order.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
  // Width needed to hold the values 0..n inclusive.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Width of an index into n entries.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/mrw_credit.sv
module mrw_credit #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = mrw_pkg::cnt_bits(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          give_i,
  output logic          room_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({take_i, give_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign room_o = (cnt_q < CW'(DEPTH));
  assign cnt_o  = cnt_q;

  // R4: the count never passes the buffer depth
  assert_credit_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/mrw_valid_pipe.sv
module mrw_valid_pipe #(
  parameter int unsigned LAT = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           issue_i,
  output logic [LAT-1:0] stages_o,
  output logic           land_o
);
  logic [LAT-1:0] sr_q;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= issue_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[LAT-2:0], issue_i};
      end
    end
  endgenerate

  assign stages_o = sr_q;
  assign land_o   = sr_q[LAT-1];
endmodule

// File: rtl/mrw_fifo.sv
module mrw_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = mrw_pkg::idx_bits(DEPTH),
  localparam int unsigned CW = mrw_pkg::cnt_bits(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] fill_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] fill_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push_i) wp_q <= bump(wp_q);
      if (pop_i)  rp_q <= bump(rp_q);
      unique case ({push_i, pop_i})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  assign valid_o = (fill_q != '0);
  assign data_o  = mem_q[rp_q];
  assign fill_o  = fill_q;

  // R5: a landing word always finds a free slot
  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (fill_q < CW'(DEPTH)));
endmodule

// File: rtl/lim_mem_wrap.sv
module lim_mem_wrap #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned LAT   = 3,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_en_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int unsigned CW = mrw_pkg::cnt_bits(DEPTH);

  initial begin
    assert (LAT >= 1 && DEPTH >= LAT)
      else $error("lim_mem_wrap: need LAT >= 1 and DEPTH >= LAT");
  end

  logic          room, acc, deq, land;
  logic [CW-1:0] credit, fill;
  logic [LAT-1:0] stages;

  assign acc         = req_valid_i && room;
  assign deq         = rsp_valid_o && rsp_ready_i;
  assign req_ready_o = room;
  assign mem_en_o    = acc;
  assign mem_addr_o  = req_addr_i;

  mrw_credit #(.DEPTH(DEPTH)) u_credit (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(acc), .give_i(deq),
    .room_o(room), .cnt_o(credit)
  );

  mrw_valid_pipe #(.LAT(LAT)) u_vpipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(acc),
    .stages_o(stages), .land_o(land)
  );

  mrw_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(land), .data_i(mem_rdata_i),
    .pop_i(deq), .valid_o(rsp_valid_o), .data_o(rsp_data_o), .fill_o(fill)
  );

  // R4: credit equals reads in flight plus buffered responses
  assert_credit_matches_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(credit) == $countones(stages) + int'(fill));

  // R6: a stalled response holds its value
  assert_rsp_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  // R2: the memory is only enabled when the request side can take a read
  assert_en_needs_room_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (req_ready_o && req_valid_i));
endmodule

// File: tb/lim_mem_wrap_tb_top.sv
module lim_mem_wrap_tb_top;
  localparam int unsigned AW = 8, DW = 16, LAT = 3, DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, rsp_valid, rsp_ready = 1'b0, mem_en;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [DW-1:0] rsp_data, mem_rdata;

  int checks = 0, errors = 0, cyc = 0;
  logic [AW-1:0] expq [256];
  int head = 0, tail = 0;
  logic last_acc;

  always #2 clk = ~clk;

  lim_mem_wrap #(.AW(AW), .DW(DW), .LAT(LAT), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_data_o(rsp_data), .mem_en_o(mem_en), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata)
  );

  // Memory model: fixed latency, content derived from address; junk when idle.
  logic          bm_v [LAT];
  logic [AW-1:0] bm_a [LAT];
  function automatic logic [DW-1:0] content(input logic [AW-1:0] a);
    return {a, a ^ 8'h5A};
  endfunction
  always_ff @(posedge clk) begin
    bm_v[0] <= rst_n && mem_en;
    bm_a[0] <= mem_addr;
    for (int i = 1; i < LAT; i++) begin
      bm_v[i] <= rst_n && bm_v[i-1];
      bm_a[i] <= bm_a[i-1];
    end
  end
  assign mem_rdata = bm_v[LAT-1] ? content(bm_a[LAT-1]) : (16'hBAD0 ^ 16'(cyc));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, score the handshakes, advance to the next negedge.
  task automatic step(input logic v, input logic [AW-1:0] a, input logic r);
    req_valid = v; req_addr = a; rsp_ready = r;
    #1;
    last_acc = req_valid && req_ready;
    if (mem_en !== last_acc) chk(0, "R2 enable", int'(mem_en), int'(last_acc));
    if (last_acc) begin
      if (mem_addr !== a) chk(0, "R2 address", int'(mem_addr), int'(a));
      expq[tail % 256] = a; tail++;
    end
    if (rsp_valid && rsp_ready) begin
      if (head == tail) chk(0, "R8 spurious response", int'(rsp_data), 0);
      else begin
        chk(rsp_data == content(expq[head % 256]), "R3 data/order",
            int'(rsp_data), int'(content(expq[head % 256])));
        head++;
      end
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) step(1'b0, '0, 1'b1);
    chk(head == tail && !rsp_valid, "R3 drain complete", tail - head, 0);
  endtask

  // {req_valid, rsp_ready, addr}
  localparam logic [9:0] VEC [16] = '{
    {2'b11, 8'h01}, {2'b11, 8'h02}, {2'b10, 8'h03}, {2'b10, 8'h04},
    {2'b10, 8'h05}, {2'b01, 8'h00}, {2'b11, 8'hFF}, {2'b00, 8'h00},
    {2'b11, 8'h80}, {2'b01, 8'h00}, {2'b10, 8'h7E}, {2'b11, 8'h10},
    {2'b00, 8'h00}, {2'b11, 8'hA5}, {2'b01, 8'h00}, {2'b11, 8'h5A}
  };

  initial begin
    logic [15:0] lfsr;
    logic [DW-1:0] held;
    int n;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk(mem_en == 1'b0, "R1 mem_en after reset", int'(mem_en), 0);
    @(negedge clk);

    // R8 junk on the memory bus while idle produces nothing
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1);
    chk(rsp_valid == 1'b0, "R8 idle junk ignored", int'(rsp_valid), 0);

    // Vector table, walked twice
    for (int pass = 0; pass < 2; pass++)
      for (int i = 0; i < 16; i++) step(VEC[i][9], VEC[i][7:0], VEC[i][8]);
    drain();

    // R3 latency from acceptance to response
    step(1'b1, 8'h33, 1'b0);
    chk(last_acc == 1'b1, "R3 single accept", int'(last_acc), 1);
    n = 0;
    while (!rsp_valid && n < 20) begin step(1'b0, '0, 1'b0); n++; end
    chk(n == LAT, "R3 response latency", n, LAT);
    drain();

    // R5 fill with consumer stalled
    n = 0;
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 8'(8'h40 + i), 1'b0);
      if (last_acc) n++;
    end
    chk(n == DEPTH, "R5 accepted while stalled", n, DEPTH);
    chk(req_ready == 1'b0, "R5 ready low when full", int'(req_ready), 0);
    // R6 stalled response holds
    held = rsp_data;
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);
    chk(rsp_valid && rsp_data == held, "R6 stalled data stable", int'(rsp_data), int'(held));
    // R7 dequeue at full credit: request refused now, ready next cycle
    step(1'b1, 8'h99, 1'b1);
    chk(last_acc == 1'b0, "R7 no accept in dequeue cycle at full", int'(last_acc), 0);
    chk(req_ready == 1'b1, "R7 ready next cycle", int'(req_ready), 1);
    drain();

    // R4 simultaneous accept and dequeue keeps the count
    for (int i = 0; i < DEPTH - 1; i++) step(1'b1, 8'(8'hC0 + i), 1'b0);
    for (int i = 0; i < LAT; i++) step(1'b0, '0, 1'b0);
    step(1'b1, 8'hD0, 1'b1);
    chk(last_acc == 1'b1, "R4 accept with dequeue", int'(last_acc), 1);
    chk(req_ready == 1'b1, "R4 count unchanged on both", int'(req_ready), 1);
    step(1'b1, 8'hD1, 1'b0);
    chk(req_ready == 1'b0, "R4 one more accept reaches depth", int'(req_ready), 0);
    drain();

    // Random stalls on both sides
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[11:4], lfsr[1] & lfsr[2] | lfsr[9]);
    end
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule